// File: doc/BRIEF.md
# Polled Read FIFO with Status Word

This block buffers 32-bit words from a producer in a 32-entry synchronous FIFO and hands them to a bus master through two read-only registers on a simple register bus. The bus has four signals: select, address, read strobe and read data. Reads complete in a single cycle. A read of the data register removes the oldest entry and returns it. A read of the status register returns the empty and full flags, two sticky error flags and the current entry count packed into one word.

The block does not stall or refuse a data read when the FIFO is empty. Software is expected to poll the status register first. If it reads the data register anyway, nothing is removed, the bus repeats the last word that was actually popped, and the read error flag records the mistake. The producer is told about a full FIFO through a dedicated output. A word it pushes while the FIFO is full is dropped and recorded in the write error flag.

Register offsets are word addresses on the bus: offset 0 is the data register and offset 1 is the status register. Every other offset is unmapped.

Top module: `stat_read_fifo`

## Requirements
- R1: After reset the FIFO is empty, the count is 0, both error flags are clear, `wr_full` is low and `rd_data` is 0.
- R2: Words come out in the order they were written. Each data read (select and read strobe high, address 0) returns its word on `rd_data` in the cycle after the strobe.
- R3: A status read (address 1) returns a word laid out as follows: bit 0 = empty, bit 1 = full, bit 2 = read error, bit 3 = write error, bits [31:26] = entry count, all other bits 0. The word reflects the state in the cycle of the strobe, before that cycle's push or pop.
- R4: A data read while the FIFO is empty removes nothing, returns the last word that was popped (0 if none has been popped since reset) and sets the read error flag.
- R5: A push while the FIFO is full is discarded and sets the write error flag. The count stays at 32.
- R6: Both error flags stay set until reset and are cleared by reset.
- R7: A push and a pop in the same cycle leave the count unchanged, and both words keep their place in order.
- R8: Each cycle with a data read removes exactly one entry when the FIFO is not empty. Data reads on back-to-back cycles pop consecutive entries.
- R9: A read at any offset other than 0 or 1 returns 0 and changes neither the FIFO contents nor the flags.
- R10: `wr_full` is high exactly when the count is 32. The count never exceeds 32.
- R11: A read strobe with select low has no effect on the FIFO or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Producer push request |
| wr_data | input | 32 | Producer push word |
| wr_full | output | 1 | FIFO holds 32 entries |
| rd_sel | input | 1 | Bus select |
| rd_addr | input | 4 | Bus word offset |
| rd_strobe | input | 1 | Bus read strobe |
| rd_data | output | 32 | Registered bus read data |

## Verification
A corrupted pointer or count shows up at the bus on the next data read as an out-of-order word, or on the next status read as a wrong count field, one cycle after the strobe. A pop that wrongly happened or wrongly did not happen on an empty access shows up as a shift of every later word returned by the scoreboard, so a single error keeps producing miscompares until the FIFO drains. Error flags that clear or set at the wrong time appear in the status word in the cycle after the next status strobe, and an unmapped access that leaks into the FIFO shows up as a changed count in the following status read.

// File: rtl/mrf_pkg.sv
package mrf_pkg;
    // status word low flag positions (decoded by software)
    localparam int ST_EMPTY = 0;
    localparam int ST_FULL  = 1;
    localparam int ST_RERR  = 2;
    localparam int ST_WERR  = 3;

    // register word offsets
    localparam int OFF_DATA   = 0;
    localparam int OFF_STATUS = 1;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_DATA,
        ACC_STATUS,
        ACC_OTHER
    } acc_e;
endpackage

// File: rtl/mrf_store.sv
module mrf_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/mrf_ctrl.sv
module mrf_ctrl #(
    parameter int DEPTH  = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             push_ok,
    output logic             pop_ok,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full,
    output logic             rd_err,
    output logic             wr_err
);
    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
        logic             rd_err;
        logic             wr_err;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) begin
            return '0;
        end
        return p + PTR_W'(1);
    endfunction

    assign empty   = (st_q.count == '0);
    assign full    = (st_q.count == CNT_W'(DEPTH));
    assign push_ok = push_req && !full;
    assign pop_ok  = pop_req && !empty;

    always_comb begin
        st_d = st_q;
        if (push_ok) begin
            st_d.wr_ptr = ptr_next(st_q.wr_ptr);
        end
        if (pop_ok) begin
            st_d.rd_ptr = ptr_next(st_q.rd_ptr);
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.count = st_q.count + CNT_W'(1);
            2'b01:   st_d.count = st_q.count - CNT_W'(1);
            default: st_d.count = st_q.count;
        endcase
        if (pop_req && empty) begin
            st_d.rd_err = 1'b1;
        end
        if (push_req && full) begin
            st_d.wr_err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr = st_q.wr_ptr;
    assign rd_ptr = st_q.rd_ptr;
    assign count  = st_q.count;
    assign rd_err = st_q.rd_err;
    assign wr_err = st_q.wr_err;

    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    assert_push_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && !pop_ok) |=> count == $past(count) + CNT_W'(1));

    assert_push_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_ok) |=> $stable(count));

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty) |=> rd_err && $stable(rd_ptr));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full && !pop_ok) |=> full && wr_err && $stable(wr_ptr));

    assert_rerr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |=> rd_err);

    assert_werr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> wr_err);
endmodule

// File: rtl/mrf_regif.sv
module mrf_regif
    import mrf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              empty,
    input  logic              full,
    input  logic              rd_err,
    input  logic              wr_err,
    input  logic [CNT_W-1:0]  count,
    input  logic              pop_ok,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              pop_req,
    output logic [DATA_W-1:0] bus_rdata
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic [DATA_W-1:0] last;
    } reg_st_t;

    reg_st_t st_d, st_q;
    acc_e acc;
    logic [DATA_W-1:0] status_word;

    always_comb begin
        acc = ACC_NONE;
        if (bus_sel && bus_rd) begin
            if (bus_addr == ADDR_W'(OFF_DATA)) begin
                acc = ACC_DATA;
            end else if (bus_addr == ADDR_W'(OFF_STATUS)) begin
                acc = ACC_STATUS;
            end else begin
                acc = ACC_OTHER;
            end
        end
    end

    assign pop_req = (acc == ACC_DATA);

    always_comb begin
        status_word = '0;
        status_word[ST_EMPTY] = empty;
        status_word[ST_FULL]  = full;
        status_word[ST_RERR]  = rd_err;
        status_word[ST_WERR]  = wr_err;
        status_word[DATA_W-1 -: CNT_W] = count;
    end

    always_comb begin
        st_d = st_q;
        case (acc)
            ACC_DATA: begin
                if (pop_ok) begin
                    st_d.rdata = mem_rdata;
                    st_d.last  = mem_rdata;
                end else begin
                    st_d.rdata = st_q.last;
                end
            end
            ACC_STATUS: st_d.rdata = status_word;
            ACC_OTHER:  st_d.rdata = '0;
            default:    st_d.rdata = st_q.rdata;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;

    assert_other_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_OTHER) |=> bus_rdata == '0);

    assert_empty_repeat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_DATA && empty) |=> bus_rdata == $past(st_q.last));

    assert_pop_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop_ok |-> (bus_sel && bus_rd && bus_addr == ADDR_W'(OFF_DATA)));

    assert_unselected_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> $stable(bus_rdata));
endmodule

// File: rtl/stat_read_fifo.sv
module stat_read_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    parameter int ADDR_W = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rd_sel,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rd_data
);
    logic              push_ok, pop_ok, pop_req;
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              empty, full, rd_err, wr_err;
    logic [DATA_W-1:0] mem_rdata;

    mrf_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (wr_en),
        .pop_req  (pop_req),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .count    (count),
        .empty    (empty),
        .full     (full),
        .rd_err   (rd_err),
        .wr_err   (wr_err)
    );

    mrf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
        .clk     (clk),
        .wr_en   (push_ok),
        .wr_addr (wr_ptr),
        .wr_data (wr_data),
        .rd_addr (rd_ptr),
        .rd_data (mem_rdata)
    );

    mrf_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) regif_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (rd_sel),
        .bus_addr  (rd_addr),
        .bus_rd    (rd_strobe),
        .empty     (empty),
        .full      (full),
        .rd_err    (rd_err),
        .wr_err    (wr_err),
        .count     (count),
        .pop_ok    (pop_ok),
        .mem_rdata (mem_rdata),
        .pop_req   (pop_req),
        .bus_rdata (rd_data)
    );

    assign wr_full = full;

    assert_full_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_full |-> !empty);
endmodule

// File: tb/stat_read_fifo_tb.sv
`timescale 1ns/1ps
module stat_read_fifo_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_full;
    logic        rd_sel = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic        rd_strobe = 1'b0;
    logic [31:0] rd_data;

    int vectors = 0;
    int errors  = 0;

    logic [31:0] model_q[$];
    logic [31:0] m_last = '0;
    logic        m_rerr = 1'b0;
    logic        m_werr = 1'b0;

    logic [31:0] exp_data[$];
    string       exp_tag[$];

    always #2.5 clk = ~clk;

    stat_read_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(wr_full), .rd_sel(rd_sel), .rd_addr(rd_addr),
        .rd_strobe(rd_strobe), .rd_data(rd_data)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] status_model();
        logic [31:0] s = '0;
        s[0] = (model_q.size() == 0);
        s[1] = (model_q.size() == 32);
        s[2] = m_rerr;
        s[3] = m_werr;
        s[31:26] = 6'(model_q.size());
        return s;
    endfunction

    // one bus/producer cycle; called just after a falling edge
    task automatic step(input logic push, input logic [31:0] pd, input logic sel,
                        input logic rd, input logic [3:0] addr, input string tag);
        logic was_full  = (model_q.size() == 32);
        logic was_empty = (model_q.size() == 0);
        logic [31:0] st = status_model();
        wr_en = push; wr_data = pd; rd_sel = sel; rd_strobe = rd; rd_addr = addr;
        if (sel && rd) begin
            if (addr == 4'd0) begin
                if (!was_empty) begin
                    m_last = model_q.pop_front();
                end else begin
                    m_rerr = 1'b1;
                end
                exp_data.push_back(m_last);
            end else if (addr == 4'd1) begin
                exp_data.push_back(st);
            end else begin
                exp_data.push_back(32'h0);
            end
            exp_tag.push_back(tag);
        end
        if (push) begin
            if (was_full) m_werr = 1'b1;
            else model_q.push_back(pd);
        end
        @(negedge clk);
        wr_en = 1'b0; rd_sel = 1'b0; rd_strobe = 1'b0;
    endtask

    task automatic push(input logic [31:0] d, input string tag);
        step(1'b1, d, 1'b0, 1'b0, 4'd0, tag);
    endtask
    task automatic rd(input logic [3:0] a, input string tag);
        step(1'b0, 32'h0, 1'b1, 1'b1, a, tag);
    endtask

    // scoreboard monitor: compare the word returned for each strobe
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && rd_sel && rd_strobe) begin
                if (exp_data.size() == 0) begin
                    errors++;
                    $display("FAIL scoreboard underrun actual=%h expected=none", rd_data);
                end else begin
                    check(rd_data, exp_data.pop_front(), exp_tag.pop_front());
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_q.delete();
        m_last = '0; m_rerr = 1'b0; m_werr = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        check(rd_data, 32'h0, "R1 rd_data after reset");
        check({31'h0, wr_full}, 32'h0, "R1 wr_full after reset");
        rd(4'd1, "R1 R3 status after reset");

        // R4 data read on empty
        rd(4'd0, "R4 empty read returns 0");
        rd(4'd1, "R4 R3 status shows read error");

        // R2 order with a few words
        for (int i = 0; i < 5; i++) push(32'hC0DE_0000 + i, "R2 push");
        rd(4'd1, "R3 status count 5");
        for (int i = 0; i < 5; i++) rd(4'd0, "R2 ordered pop");
        rd(4'd0, "R4 empty read repeats last word");

        // R5 R10 fill and overflow
        for (int i = 0; i < 32; i++) push(32'hA500_0000 + i, "R10 fill");
        check({31'h0, wr_full}, 32'h1, "R10 wr_full at 32");
        rd(4'd1, "R3 R10 status at full");
        push(32'hDEAD_BEEF, "R5 overflow push");
        rd(4'd1, "R5 status after overflow");
        check({31'h0, wr_full}, 32'h1, "R5 still full");

        // R9 unmapped offsets
        rd(4'd2, "R9 offset 2 zero");
        rd(4'd15, "R9 offset 15 zero");
        // R11 unselected strobe
        step(1'b0, 32'h0, 1'b0, 1'b1, 4'd0, "R11 unselected");
        rd(4'd1, "R9 R11 status unchanged");

        // R8 back-to-back pops
        for (int i = 0; i < 20; i++) rd(4'd0, "R8 back-to-back pop");
        rd(4'd1, "R8 status count 12");

        // R7 simultaneous push and pop
        for (int i = 0; i < 6; i++) step(1'b1, 32'h7700_0000 + i, 1'b1, 1'b1, 4'd0, "R7 push+pop");
        rd(4'd1, "R7 count unchanged");
        for (int i = 0; i < 12; i++) rd(4'd0, "R7 R2 drain order");
        step(1'b1, 32'h1234_5678, 1'b1, 1'b1, 4'd0, "R4 empty read with push");
        rd(4'd0, "R2 word pushed during empty read");
        rd(4'd1, "R6 errors sticky");

        // R6 reset clears errors
        do_reset();
        check(rd_data, 32'h0, "R1 rd_data after second reset");
        rd(4'd1, "R6 status after reset");
        @(negedge clk);
        if (exp_data.size() != 0) begin
            errors++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", exp_data.size());
        end
        finish_run();
    end
endmodule